// File: doc/BRIEF.md
# Data-Space Router with On-Chip RAM Window

This block sits between a processor core and its 64 KB data address space. Each access the core issues is decoded once. If the address lands in a window of on-chip RAM, that RAM serves it and the access completes in one cycle. Otherwise it goes out over a simple external bus that has separate read and write strobes, and the core is held busy until the bus acknowledges. Because the on-chip window shadows the same addresses on the external bus, any access that hits the window never produces an external strobe.

The core can also issue a short access that carries only an 8-bit offset. The block completes it to 16 bits with an 8-bit page register. That register resets to zero, so short accesses reach the lowest 256 bytes unless software loads another page. The window base and size are parameters. A size of zero removes the window and its storage, and every access then goes to the external bus. The window is always usable and has no enable input.

Top module: `xdata_router`

## Requirements
- R1: The effective address is `req_addr` when `req_paged` is 0. When `req_paged` is 1 it is {page register, `req_addr[7:0]`} and `req_addr[15:8]` is ignored. The page register resets to 0x00 and loads `pg_data` on any cycle with `pg_wr` high.
- R2: An access is accepted on a clock edge where `req_valid` is high and `busy` is low. If its effective address A satisfies WIN_BASE <= A <= WIN_BASE+WIN_SIZE-1, it is served by on-chip storage. The defaults are base 0xF800 and size 2048, so 0xF800..0xFFFF hit and 0xF7FF does not.
- R3: For a window hit, `done` is high for exactly the one cycle after the accepting edge and `busy` stays low. A window read returns the byte most recently written to that address on `rdata` during that cycle.
- R4: An accepted window hit never raises `ext_rd` or `ext_wr`.
- R5: An accepted access outside the window raises `ext_rd` (read) or `ext_wr` (write) from the cycle after acceptance. The strobe is held, with `ext_addr` equal to the effective address and `ext_wdata` equal to the write data, up to and including the cycle in which `ext_ack` is sampled high.
- R6: `busy` is high exactly while an external access waits for `ext_ack`. After the edge that samples `ext_ack` high, `busy` is low and `done` is high for one cycle. For a read, `rdata` then holds `ext_rdata` as sampled at that edge.
- R7: A request presented while `busy` is high is ignored: no storage is written and the pending external access is unchanged.
- R8: `ext_rd` and `ext_wr` are never high together, and after reset `busy`, `done`, both strobes and `rdata` are 0.
- R9: With WIN_SIZE = 0 there is no window, and every address, including 0xF800..0xFFFF, goes to the external bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_wr | input | 1 | Load the page register |
| pg_data | input | 8 | New page register value |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_paged | input | 1 | 1 = 8-bit paged access |
| req_addr | input | 16 | Access address (low byte only when paged) |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | External access pending; core must wait |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with `done` |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External bus read data |
| ext_ack | input | 1 | External bus acknowledge |

## Verification
The assertions check on every cycle that the two strobes are exclusive, that a window hit leaves both strobes low and completes on the next cycle, and that a pending external access holds its address and data until the acknowledge and then finishes with a single `done`. Only the bench's scenarios can show that the data is right. That means window reads returning earlier writes, external reads returning what the bus supplied, paged addresses formed from the page register, the exact edges of the window, a request made while busy leaving no trace, and a zero-size build sending the top of the space off-chip.

// File: rtl/xr_pkg.sv
// Shared widths and types for the data-space router.
// Assumes a byte-wide data path and a 16-bit address space.
package xr_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 8;

    typedef enum logic {
        XB_IDLE = 1'b0,
        XB_WAIT = 1'b1
    } xb_state_t;
endpackage

// File: rtl/xr_decode.sv
// Forms the effective address (full or paged) and decides whether it falls
// inside the on-chip window. Purely combinational; assumes the window does
// not extend past the top of the address space.
module xr_decode
    import xr_pkg::*;
#(
    parameter int unsigned WIN_BASE = 32'h0000_F800,
    parameter int unsigned WIN_SIZE = 32'd2048
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              paged,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              hit
);
    localparam int unsigned WIN_LIMIT = WIN_BASE + WIN_SIZE;
    localparam int unsigned OFS_W     = ADDR_W - PAGE_W;

    logic [31:0] wide_addr;

    // Effective address: the page register supplies the high byte for paged accesses.
    always_comb begin
        if (paged) begin
            eff_addr = {page, addr[OFS_W-1:0]};
        end else begin
            eff_addr = addr;
        end
        wide_addr = {{(32-ADDR_W){1'b0}}, eff_addr};
    end

    // Window compare against base and base+size-1; a zero size never hits.
    always_comb begin
        hit = (WIN_SIZE != 0) && (wide_addr >= WIN_BASE) && (wide_addr < WIN_LIMIT);
    end
endmodule

// File: rtl/xr_ram.sv
// On-chip storage behind the window. A write or read completes at the
// accepting edge; read data is registered. Assumes callers only assert
// the access strobe for addresses that hit the window. With WIN_SIZE = 0
// no storage is built and the read port returns zero.
module xr_ram
    import xr_pkg::*;
#(
    parameter int unsigned WIN_BASE = 32'h0000_F800,
    parameter int unsigned WIN_SIZE = 32'd2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              we,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q
);
    generate
        if (WIN_SIZE > 0) begin : g_store
            localparam int OFF_W = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1;
            localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);

            logic [DATA_W-1:0] mem [WIN_SIZE];
            logic [ADDR_W-1:0] rel;
            logic [OFF_W-1:0]  off;

            // Offset of the access inside the window.
            always_comb begin
                rel = eff_addr - BASE_A;
                off = rel[OFF_W-1:0];
            end

            // Storage write port; contents are not reset.
            always_ff @(posedge clk) begin
                if (acc && we) begin
                    mem[off] <= wdata;
                end
            end

            // Registered read port, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_q <= '0;
                end else if (acc && !we) begin
                    rd_q <= mem[off];
                end
            end

            logic unused_rel;
            assign unused_rel = ^rel;
        end else begin : g_none
            assign rd_q = '0;
            logic unused_in;
            assign unused_in = ^{clk, rst_n, acc, we, eff_addr, wdata};
        end
    endgenerate
endmodule

// File: rtl/xr_ext_bus.sv
// External bus sequencer: latches one access, drives the read or write
// strobe until the bus acknowledges, then pulses done for one cycle.
// Assumes start is only raised while busy is low.
module xr_ext_bus
    import xr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    xb_state_t         state;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    // Sequencer: capture on start, hold until acknowledge, then complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= XB_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                XB_IDLE: begin
                    if (start) begin
                        we_q    <= start_we;
                        addr_q  <= start_addr;
                        wdata_q <= start_wdata;
                        state   <= XB_WAIT;
                    end
                end
                XB_WAIT: begin
                    if (ext_ack) begin
                        if (!we_q) begin
                            rdata_q <= ext_rdata;
                        end
                        done_q <= 1'b1;
                        state  <= XB_IDLE;
                    end
                end
                default: state <= XB_IDLE;
            endcase
        end
    end

    // Bus outputs follow the latched access while waiting.
    always_comb begin
        busy      = (state == XB_WAIT);
        ext_rd    = busy && !we_q;
        ext_wr    = busy && we_q;
        ext_addr  = addr_q;
        ext_wdata = wdata_q;
        done      = done_q;
        rdata     = rdata_q;
    end

    // R8: never both strobes.
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    // R5: a started access shows a strobe on the next cycle.
    a_r5_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (ext_rd || ext_wr));

    // R5: address, data and strobe hold until acknowledge.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ext_ack) |=> (busy && $stable(ext_addr) && $stable(ext_wdata)
                                && $stable(ext_wr)));

    // R6: acknowledge ends the wait with a done pulse.
    a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_ack) |=> (done && !busy && !ext_rd && !ext_wr));
endmodule

// File: rtl/xdata_router.sv
// Top of the data-space router. Holds the page register, accepts one
// access per idle cycle, steers window hits to on-chip storage and all
// other addresses to the external bus sequencer, and merges completions.
// Assumes the core waits for done (or at least for busy low) between accesses.
module xdata_router
    import xr_pkg::*;
#(
    parameter int unsigned WIN_BASE = 32'h0000_F800,
    parameter int unsigned WIN_SIZE = 32'd2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_wr,
    input  logic [PAGE_W-1:0] pg_data,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_paged,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ack
);
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] eff_addr;
    logic              hit;
    logic              accept;
    logic              win_acc;
    logic              ext_start;
    logic              win_done;
    logic [DATA_W-1:0] win_rd;
    logic              ext_busy;
    logic              ext_done;
    logic [DATA_W-1:0] ext_rd_data;

    // Page register for short accesses; resets to page zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (pg_wr) begin
            page_q <= pg_data;
        end
    end

    xr_decode #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_decode (
        .page     (page_q),
        .paged    (req_paged),
        .addr     (req_addr),
        .eff_addr (eff_addr),
        .hit      (hit)
    );

    // Acceptance and steering of the request.
    always_comb begin
        accept    = req_valid && !ext_busy;
        win_acc   = accept && hit;
        ext_start = accept && !hit;
    end

    xr_ram #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (win_acc),
        .we       (req_write),
        .eff_addr (eff_addr),
        .wdata    (req_wdata),
        .rd_q     (win_rd)
    );

    xr_ext_bus u_ext (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (ext_start),
        .start_we    (req_write),
        .start_addr  (eff_addr),
        .start_wdata (req_wdata),
        .ext_ack     (ext_ack),
        .ext_rdata   (ext_rdata),
        .ext_rd      (ext_rd),
        .ext_wr      (ext_wr),
        .ext_addr    (ext_addr),
        .ext_wdata   (ext_wdata),
        .busy        (ext_busy),
        .done        (ext_done),
        .rdata       (ext_rd_data)
    );

    // Window completion flag, one cycle after a window access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_done <= 1'b0;
        end else begin
            win_done <= win_acc;
        end
    end

    // Completion and read data merge.
    always_comb begin
        busy  = ext_busy;
        done  = win_done || ext_done;
        rdata = win_done ? win_rd : ext_rd_data;
    end

    // R4: a window hit never reaches the external strobes.
    a_r4_no_strobe_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        win_acc |=> (!ext_rd && !ext_wr));

    // R3: a window hit completes on the next cycle without busy.
    a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        win_acc |=> (done && !busy));

    // R6: the two completion sources never coincide.
    a_r6_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_done, ext_done}));

    // R7: a request while busy produces no window completion.
    a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !win_done);
endmodule

// File: tb/xdata_router_test.sv
module xdata_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int WBASE = 16'hF800;
    localparam int WSIZE = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr = 1'b0;
    logic [7:0]  pg_data = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_paged = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, ext_rd, ext_wr;
    logic [7:0]  rdata, ext_wdata;
    logic [15:0] ext_addr;
    logic [7:0]  ext_rdata = '0;
    logic        ext_ack = 1'b0;

    logic        z_busy, z_done, z_rd, z_wr;
    logic [7:0]  z_rdata, z_wdata;
    logic [15:0] z_addr;

    int checks = 0;
    int fails  = 0;
    logic [7:0] pg_model = 8'h00;
    logic [7:0] win_ref [WSIZE];
    logic [7:0] ext_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    xdata_router uut (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_data(pg_data),
        .req_valid(req_valid), .req_write(req_write), .req_paged(req_paged),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    // Build with no window: always acknowledges, returns a fixed byte.
    xdata_router #(.WIN_BASE(32'h0), .WIN_SIZE(32'd0)) uut0 (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_data(pg_data),
        .req_valid(req_valid), .req_write(req_write), .req_paged(req_paged),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(z_busy), .done(z_done),
        .rdata(z_rdata), .ext_rd(z_rd), .ext_wr(z_wr), .ext_addr(z_addr),
        .ext_wdata(z_wdata), .ext_rdata(8'h5A), .ext_ack(1'b1)
    );

    function automatic logic exp_hit(input logic [15:0] a);
        return (int'(a) >= WBASE) && (int'(a) < WBASE + WSIZE);
    endfunction

    function automatic logic [15:0] exp_addr(input logic paged, input logic [7:0] pg,
                                             input logic [15:0] a);
        return paged ? {pg, a[7:0]} : a;
    endfunction

    function automatic logic [7:0] ext_key(input logic [15:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_page(input logic [7:0] p);
        @(negedge clk);
        pg_wr = 1'b1;
        pg_data = p;
        @(negedge clk);
        pg_wr = 1'b0;
        pg_model = p;
    endtask

    // One access; delay = ack wait cycles; poke = issue a stray request while busy.
    task automatic do_access(input logic paged, input logic wr, input logic [15:0] a,
                             input logic [7:0] wd, input int delay, input logic poke);
        logic [15:0] fa;
        logic [7:0]  expd;
        fa = exp_addr(paged, pg_model, a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_paged = paged;
        req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit(fa)) begin
            chk(done === 1'b1, "R3 hit done", int'(done), 1);
            chk(busy === 1'b0, "R3 hit busy", int'(busy), 0);
            chk(!ext_rd && !ext_wr, "R4 strobes on hit", int'({ext_rd, ext_wr}), 0);
            if (wr) begin
                win_ref[int'(fa) - WBASE] = wd;
            end else begin
                expd = win_ref[int'(fa) - WBASE];
                chk(rdata === expd, "R2 window read", int'(rdata), int'(expd));
            end
        end else begin
            chk(busy === 1'b1, "R6 busy", int'(busy), 1);
            chk(ext_rd === !wr && ext_wr === wr, "R5 strobe", int'({ext_rd, ext_wr}),
                int'({!wr, wr}));
            chk(ext_addr === fa, "R1 ext addr", int'(ext_addr), int'(fa));
            if (wr) chk(ext_wdata === wd, "R5 ext wdata", int'(ext_wdata), int'(wd));
            for (int i = 0; i < delay; i++) begin
                if (poke && i == 0) begin
                    req_valid = 1'b1; req_write = 1'b1; req_paged = 1'b0;
                    req_addr = 16'hF810; req_wdata = 8'hEE;
                end
                @(posedge clk);
                @(negedge clk);
                req_valid = 1'b0;
                chk(busy === 1'b1 && done === 1'b0, "R6 wait", int'({busy, done}), 2);
                chk(ext_addr === fa && (ext_rd || ext_wr), "R5 hold", int'(ext_addr), int'(fa));
            end
            expd = ext_mem[ext_key(fa)];
            ext_ack = 1'b1;
            ext_rdata = expd;
            @(posedge clk);
            @(negedge clk);
            ext_ack = 1'b0;
            ext_rdata = 8'h00;
            chk(done === 1'b1 && busy === 1'b0, "R6 complete", int'({done, busy}), 2);
            chk(!ext_rd && !ext_wr, "R6 strobes drop", int'({ext_rd, ext_wr}), 0);
            if (wr) ext_mem[ext_key(fa)] = wd;
            else chk(rdata === expd, "R6 ext read", int'(rdata), int'(expd));
        end
        @(negedge clk);
        chk(done === 1'b0, "R3 done single cycle", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] a;
        logic        p, w;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) ext_mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(!busy && !done && !ext_rd && !ext_wr && rdata == 8'h00, "R8 reset",
            int'({busy, done, ext_rd, ext_wr, rdata}), 0);
        rst_n = 1'b1;

        // Fill the window so every read has a known value.
        for (int i = 0; i < WSIZE; i++) begin
            do_access(1'b0, 1'b1, 16'(WBASE + i), 8'(i ^ (i >> 3)), 0, 1'b0);
        end

        // R2 boundaries
        do_access(1'b0, 1'b0, 16'hF800, 8'h00, 0, 1'b0);
        do_access(1'b0, 1'b0, 16'hFFFF, 8'h00, 0, 1'b0);
        do_access(1'b0, 1'b0, 16'hF7FF, 8'h00, 2, 1'b0);
        do_access(1'b0, 1'b1, 16'hF7FF, 8'hA5, 1, 1'b0);
        do_access(1'b0, 1'b0, 16'hF7FF, 8'h00, 0, 1'b0);

        // R1: page resets to zero; upper address byte ignored when paged
        do_access(1'b1, 1'b0, 16'hF833, 8'h00, 1, 1'b0);
        set_page(8'hF8);
        do_access(1'b1, 1'b1, 16'h0020, 8'h3C, 0, 1'b0);
        do_access(1'b0, 1'b0, 16'hF820, 8'h00, 0, 1'b0);
        set_page(8'h12);
        do_access(1'b1, 1'b0, 16'hFF44, 8'h00, 3, 1'b0);

        // R7: stray write to the window while busy must not land
        do_access(1'b0, 1'b1, 16'hF810, 8'h11, 0, 1'b0);
        do_access(1'b0, 1'b0, 16'h1234, 8'h00, 3, 1'b1);
        do_access(1'b0, 1'b0, 16'hF810, 8'h00, 0, 1'b0);
        chk(win_ref[16'h10] == 8'h11, "R7 model", int'(win_ref[16'h10]), 8'h11);

        // R9: zero-size build sends a window address off-chip
        repeat (3) @(negedge clk);
        chk(z_busy === 1'b0, "R9 idle", int'(z_busy), 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_paged = 1'b0; req_addr = 16'hF900;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(z_rd === 1'b1 && z_busy === 1'b1, "R9 external strobe", int'({z_rd, z_busy}), 3);
        chk(z_addr === 16'hF900, "R9 addr", int'(z_addr), 16'hF900);
        chk(!ext_rd && !ext_wr && done, "R4 main build hit", int'({ext_rd, ext_wr, done}), 1);
        @(posedge clk);
        @(negedge clk);
        chk(z_done === 1'b1 && z_rdata === 8'h5A, "R9 done", int'(z_rdata), 8'h5A);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            p = ($urandom % 4) == 0;
            w = $urandom % 2;
            if (p && ($urandom % 3) == 0) set_page(($urandom % 2) ? 8'(16'hF8 + $urandom % 8) : 8'($urandom));
            if ($urandom % 2) a = 16'(WBASE + $urandom % WSIZE);
            else a = 16'($urandom);
            do_access(p, w, a, 8'($urandom), int'($urandom % 4), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule